// File: doc/BRIEF.md
# Rename Table with Known-Zero Tracking

This block holds the current binding from every architectural integer register to a physical register index, for the rename stage of an out-of-order core. It serves a decode window of several instructions per cycle. Each window slot has two source lookup ports and one destination binding port. Architectural register x0 has no storage. Looking it up always yields physical register 0, which is the physical register wired to the constant zero.

Each binding carries a known-zero flag. The flag is set whenever the register is bound to physical register 0. Every binding port compares its incoming physical index against 0 and updates the flag together with the binding. The complete vector of known-zero flags is driven out every cycle. Downstream logic uses it to spot moves, no-ops and other operations that can be resolved early. Lookups are combinational and show the table as it stood before the current cycle's bindings. New bindings take hold at the next clock edge. When several slots bind the same register in one cycle, they are applied in program order.

Top module: `rename_map`

## Requirements
- R1: While reset is held and after it is released, every architectural register reads as physical 0 with its known-zero flag set, and every bit of `zero_vec` is 1.
- R2: A lookup port returns the physical index most recently bound to the requested architectural register, together with that register's known-zero flag.
- R3: A lookup of x0 (index 0) always returns physical 0 with the zero flag set. A binding aimed at x0 changes nothing, and `zero_vec[0]` stays 1.
- R4: A binding to physical 0 sets the register's known-zero flag. A binding to any other physical index clears it.
- R5: When several enabled slots bind the same architectural register in one cycle, the highest-numbered (youngest) slot's index is the one kept.
- R6: Lookups are combinational. A lookup in the same cycle as a binding to that register returns the old binding, and the new one is visible after the next rising clock edge.
- R7: `zero_vec[i]` equals 1 exactly when architectural register i is bound to physical 0, in every cycle.
- R8: A slot whose `wr_en` bit is 0 changes no binding, whatever its arch and phys inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_arch | input | 2*SLOTS*AW | Lookup port p uses bits [p*AW +: AW]. Slot s owns ports 2s and 2s+1 |
| rd_phys | output | 2*SLOTS*PW | Physical index for lookup port p at [p*PW +: PW] |
| rd_zero | output | 2*SLOTS | Known-zero flag for each lookup port |
| wr_en | input | SLOTS | Binding enable per slot. Bit 0 is the oldest slot |
| wr_arch | input | SLOTS*AW | Destination architectural register for slot s at [s*AW +: AW] |
| wr_phys | input | SLOTS*PW | New physical index for slot s at [s*PW +: PW] |
| zero_vec | output | NUM_ARCH | Known-zero flag of every architectural register. Bit 0 is x0 |

## Verification
Two kinds of event meet in one cycle, and both have to be checked. The first is a lookup and a binding of the same register in one cycle: the lookup must still return the old binding. The second is two or more slots binding the same register: the youngest slot must win, and its known-zero flag must win with it. The bench provokes both by confining register numbers to a small range during long mixed runs. It also runs directed cycles in which all four slots target one register and alternate between physical 0 and nonzero indices. A behavioural model applies each cycle's bindings in slot order after comparing every lookup port and the whole zero vector against its pre-edge state.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int SLOTS    = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int RP = 2 * SLOTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RP*AW-1:0]      rd_arch,
  output logic [RP*PW-1:0]      rd_phys,
  output logic [RP-1:0]         rd_zero,
  input  logic [SLOTS-1:0]      wr_en,
  input  logic [SLOTS*AW-1:0]   wr_arch,
  input  logic [SLOTS*PW-1:0]   wr_phys,
  output logic [NUM_ARCH-1:0]   zero_vec
);

  logic [PW-1:0]       map [NUM_ARCH];
  logic [NUM_ARCH-1:0] zbit;
  logic [SLOTS-1:0]    win;
  logic [NUM_ARCH-1:0] hit;

  assign zero_vec = zbit;

  for (genvar p = 0; p < RP; p++) begin : g_rd
    logic [AW-1:0] sel;
    assign sel = rd_arch[p*AW +: AW];
    assign rd_phys[p*PW +: PW] = (sel == '0) ? '0 : map[sel];
    assign rd_zero[p] = (sel == '0) ? 1'b1 : zbit[sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map[i] <= '0;
      zbit <= '1;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (wr_en[k] && wr_arch[k*AW +: AW] != '0) begin
          map[wr_arch[k*AW +: AW]]  <= wr_phys[k*PW +: PW];
          zbit[wr_arch[k*AW +: AW]] <= (wr_phys[k*PW +: PW] == '0);
        end
      end
    end
  end

  // Slot k's binding survives when no younger enabled slot targets the same register.
  always_comb begin
    win = '0;
    for (int k = 0; k < SLOTS; k++) begin
      win[k] = wr_en[k] && (wr_arch[k*AW +: AW] != '0);
      for (int j = k + 1; j < SLOTS; j++)
        if (wr_en[j] && wr_arch[j*AW +: AW] == wr_arch[k*AW +: AW]) win[k] = 1'b0;
    end
  end

  always_comb begin
    hit = '0;
    for (int k = 0; k < SLOTS; k++)
      if (win[k]) hit[wr_arch[k*AW +: AW]] = 1'b1;
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_wchk
    assert_bind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      win[k] |=> map[$past(wr_arch[k*AW +: AW])] == $past(wr_phys[k*PW +: PW]));
    assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win[k] |=> zero_vec[$past(wr_arch[k*AW +: AW])] == ($past(wr_phys[k*PW +: PW]) == '0));
  end

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_rchk
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(map[i]) && $stable(zero_vec[i]));
    assert_zvec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      zero_vec[i] == (map[i] == '0));
  end

endmodule

// File: tb/rename_map_tb.sv
`timescale 1ns/1ps
module rename_map_tb;
  localparam int NA = 32, NP = 64, S = 4, AW = 5, PW = 6, RP = 8;

  logic clk = 0, rst_n = 0;
  logic [RP*AW-1:0] rd_arch = '0;
  logic [RP*PW-1:0] rd_phys;
  logic [RP-1:0]    rd_zero;
  logic [S-1:0]     wr_en = '0;
  logic [S*AW-1:0]  wr_arch = '0;
  logic [S*PW-1:0]  wr_phys = '0;
  logic [NA-1:0]    zero_vec;

  int model [NA];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rename_map u_dut (.clk(clk), .rst_n(rst_n), .rd_arch(rd_arch), .rd_phys(rd_phys),
    .rd_zero(rd_zero), .wr_en(wr_en), .wr_arch(wr_arch), .wr_phys(wr_phys),
    .zero_vec(zero_vec));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < RP; p++) begin
      int a, e;
      a = int'(rd_arch[p*AW +: AW]);
      e = (a == 0) ? 0 : model[a];
      chk(tag, $sformatf("port%0d phys (x%0d)", p, a), int'(rd_phys[p*PW +: PW]), e);
      chk(tag, $sformatf("port%0d zero (x%0d)", p, a), int'(rd_zero[p]), int'(e == 0));
    end
    for (int i = 0; i < NA; i++)
      chk(tag, $sformatf("zero_vec[%0d]", i), int'(zero_vec[i]), int'(i == 0 || model[i] == 0));
  endtask

  // Compare with current inputs, advance model, cross the rising edge, return at falling edge.
  task automatic step(input string tag);
    #1;
    compare(tag);
    if (rst_n) begin
      for (int k = 0; k < S; k++)
        if (wr_en[k] && wr_arch[k*AW +: AW] != 0) model[wr_arch[k*AW +: AW]] = int'(wr_phys[k*PW +: PW]);
    end else begin
      for (int i = 0; i < NA; i++) model[i] = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rand_reads(input int lim);
    for (int p = 0; p < RP; p++) rd_arch[p*AW +: AW] = AW'($urandom_range(lim, 0));
  endtask

  task automatic setw(input int k, input bit en, input int a, input int ph);
    wr_en[k] = en;
    wr_arch[k*AW +: AW] = AW'(a);
    wr_phys[k*PW +: PW] = PW'(ph);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) model[i] = 0;
    @(negedge clk);
    // R1: reset state, with bindings offered during reset that must be dropped
    for (int c = 0; c < 3; c++) begin
      rand_reads(NA - 1);
      for (int k = 0; k < S; k++) setw(k, 1'b1, k + 3, k + 9);
      step("R1");
    end
    rst_n = 1;
    wr_en = '0;
    for (int c = 0; c < 8; c++) begin rand_reads(NA - 1); step("R1"); end

    // R6/R2: read in the same cycle as the write, then after the edge
    setw(0, 1'b1, 5, 17);
    rd_arch = '0;
    for (int p = 0; p < RP; p++) rd_arch[p*AW +: AW] = 5'd5;
    step("R6");
    wr_en = '0;
    step("R2");

    // R3: bindings aimed at x0 are ignored
    for (int k = 0; k < S; k++) setw(k, 1'b1, 0, 40 + k);
    rd_arch = '0;
    step("R3");
    wr_en = '0;
    step("R3");

    // R4: bind to physical 0, then to a nonzero index
    setw(0, 1'b1, 5, 0); setw(1, 1'b1, 6, 33);
    step("R4");
    wr_en = '0;
    for (int p = 0; p < RP; p++) rd_arch[p*AW +: AW] = AW'(5 + (p % 2));
    step("R4");

    // R5: all slots hit one register; youngest wins, with zero flag alternating
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < S; k++) setw(k, 1'b1, 9, ((r + k) % 2 == 0) ? 0 : 20 + k);
      for (int p = 0; p < RP; p++) rd_arch[p*AW +: AW] = 5'd9;
      step("R5");
    end
    wr_en = '0;
    step("R5");

    // R8: disabled slots carrying live-looking data
    for (int c = 0; c < 10; c++) begin
      for (int k = 0; k < S; k++) setw(k, 1'b0, $urandom_range(NA - 1, 1), $urandom_range(NP - 1, 0));
      rand_reads(NA - 1);
      step("R8");
    end

    // R2/R5/R6/R7: mixed traffic on a narrow register range to force overlaps
    for (int c = 0; c < 3000; c++) begin
      int lim;
      lim = (c < 1500) ? 7 : NA - 1;
      for (int k = 0; k < S; k++)
        setw(k, 1'($urandom_range(1, 0)), $urandom_range(lim, 0),
             ($urandom_range(3, 0) == 0) ? 0 : $urandom_range(NP - 1, 0));
      rand_reads(lim);
      step("R7");
    end

    // R1: reset again restores all bindings to physical 0
    rst_n = 0;
    wr_en = '0;
    step("R1");
    rst_n = 1;
    rand_reads(NA - 1);
    step("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule